// File: doc/BRIEF.md
# I2C Master Arbitration Fallback Unit

This unit sits beside the bit engine of an I2C master and decides, one bit at a time, whether the master still owns the bus. The master's timing generator asks for SCL low phases, and this unit passes each request on to the SCL pull-down. For each bit it either pulls SDA low or leaves SDA released. The synchronised bus levels come back in. On every rising SCL edge the unit samples SDA once. It shifts the sample into a receive register and compares it with the level the master meant to show.

As a transmitter, the master loses arbitration when it leaves SDA high and finds it low. As a receiver, the only possible loss is in the acknowledge slot, when the master answers with a not-acknowledge and another device holds SDA low. After a loss the unit stops pulling SDA and reports slave-receiver mode. The receive register keeps filling from the bus, so the byte that another master wrote is still captured. Clocking then continues only as far as the end of the current byte's acknowledge slot. In receive mode that is the very bit in which the loss happened. A restart pulse opens a new transfer and clears the loss.

Top module: `i2c_arb_fallback`

## Requirements
- R1: Out of reset, arb_lost is 0, sda_oe is 0, rx_data is all zeros, the bit position is the first data bit, and mode_o follows role_rx (0 = master transmitter, 1 = master receiver).
- R2: In transmit mode (role_rx = 0), during each of the DATA_BITS data slots sda_oe equals the inverse of bit_val (1 pulls SDA low). During the acknowledge slot sda_oe is 0.
- R3: In transmit mode, when a rising SCL edge finds bit_val = 1 in a data slot and sda_in = 0, arb_lost becomes 1 on the next clock and mode_o becomes 2 (slave receiver).
- R4: No loss is flagged when the master drives a 0 bit or has SDA released on purpose: transmit acknowledge slot, or receive data slots. A low SDA in those slots leaves arb_lost at 0.
- R5: While arb_lost is 1, sda_oe stays 0 whatever bit_val is, until restart.
- R6: After a transmit-mode loss, scl_oe keeps following scl_req for the remaining bits up to and including the acknowledge slot. From the rising SCL edge of that slot onward, scl_oe is 0 until restart.
- R7: In receive mode (role_rx = 1), sda_oe equals the inverse of bit_val in the acknowledge slot. A rising SCL edge there with bit_val = 1 and sda_in = 0 sets arb_lost and mode_o = 2, and scl_oe is 0 from that edge onward.
- R8: Each rising SCL edge in a data slot shifts sda_in into rx_data MSB first (new bit enters bit 0). This continues after a loss, so rx_data holds the byte seen on the bus.
- R9: arb_lost is sticky. Only restart (active high, one clock) clears it, returns the bit position to the first data slot and re-enables clocking.
- R10: A bit is sampled only on the 0-to-1 change of scl_in. SCL held high for several clocks advances the bit position once. Each byte is DATA_BITS data slots followed by one acknowledge slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| restart | input | 1 | Start of a new transfer; clears loss and bit position |
| role_rx | input | 1 | 0 = master transmitter, 1 = master receiver |
| bit_val | input | 1 | Level the master wants on SDA for the current slot |
| scl_req | input | 1 | Timing generator requests SCL low |
| scl_in | input | 1 | Synchronised SCL line level |
| sda_in | input | 1 | Synchronised SDA line level |
| sda_oe | output | 1 | Pull SDA low |
| scl_oe | output | 1 | Pull SCL low |
| arb_lost | output | 1 | Sticky arbitration-lost flag |
| mode_o | output | 2 | 0 master transmitter, 1 master receiver, 2 slave receiver |
| rx_data | output | DATA_BITS | Bits sampled from the bus in the current byte |

## Verification
The bench targets a loss in the middle of a transmitted byte. A design that failed to release SDA there would corrupt the winner's data. A design that stopped the clock too early would cut the byte short, and a design that stopped shifting would hold a byte mixing both masters' bits. It also holds SDA low in slots where the master has released the line on purpose: the transmit acknowledge, and the receive data bits. A design that compared in every slot would flag a false loss there. A not-acknowledge overruled by a low acknowledge must stop the clock at once. Long SCL high phases catch a design that samples on level instead of on the edge.

// File: rtl/arbfb_pkg.sv
package arbfb_pkg;
   typedef enum logic [1:0] {
      MODE_MTX = 2'd0,
      MODE_MRX = 2'd1,
      MODE_SRX = 2'd2
   } arb_mode_e;
endpackage

// File: rtl/arbfb_bitpos.sv
// Rising-edge detector on the synchronised SCL and slot counter per byte.
module arbfb_bitpos #(
   parameter int DATA_BITS = 8,
   parameter int CNT_W     = $clog2(DATA_BITS + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             restart,
   input  logic             scl_in,
   output logic             sample,
   output logic [CNT_W-1:0] slot,
   output logic             ack_slot
);
   localparam logic [CNT_W-1:0] ACK_POS = CNT_W'(DATA_BITS);

   logic             scl_q;
   logic [CNT_W-1:0] slot_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) scl_q <= 1'b1;
      else        scl_q <= scl_in;
   end

   assign sample   = scl_in & ~scl_q;
   assign ack_slot = (slot_q == ACK_POS);
   assign slot     = slot_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       slot_q <= '0;
      else if (restart) slot_q <= '0;
      else if (sample)  slot_q <= ack_slot ? '0 : slot_q + 1'b1;
   end
endmodule

// File: rtl/arbfb_judge.sv
// Combinational drive and compare decision for the current slot.
module arbfb_judge (
   input  logic role_rx,
   input  logic bit_val,
   input  logic sda_in,
   input  logic sample,
   input  logic ack_slot,
   input  logic lost,
   output logic sda_pull,
   output logic lose_now
);
   logic own_slot;

   // transmitter owns data slots, receiver owns the acknowledge slot
   assign own_slot = role_rx ? ack_slot : ~ack_slot;
   assign sda_pull = own_slot & ~bit_val & ~lost;
   // a released 1 overruled by a low line; driving 0 is never checked
   assign lose_now = sample & own_slot & bit_val & ~sda_in & ~lost;
endmodule

// File: rtl/i2c_arb_fallback.sv
module i2c_arb_fallback
   import arbfb_pkg::*;
#(
   parameter int DATA_BITS = 8,
   parameter bit MSB_FIRST = 1'b1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 restart,
   input  logic                 role_rx,
   input  logic                 bit_val,
   input  logic                 scl_req,
   input  logic                 scl_in,
   input  logic                 sda_in,
   output logic                 sda_oe,
   output logic                 scl_oe,
   output logic                 arb_lost,
   output logic [1:0]           mode_o,
   output logic [DATA_BITS-1:0] rx_data
);
   localparam int CNT_W = $clog2(DATA_BITS + 1);

   generate
      if (DATA_BITS < 2) begin : g_bad_width
         $error("DATA_BITS must be at least 2");
      end
   endgenerate

   logic             sample;
   logic             ack_slot;
   logic [CNT_W-1:0] slot;
   logic             lose_now;
   logic             sda_pull;
   logic             lost_q;
   logic             run_q;
   logic [DATA_BITS-1:0] rx_q;
   logic [DATA_BITS-1:0] rx_nxt;
   arb_mode_e        mode;

   arbfb_bitpos #(.DATA_BITS(DATA_BITS), .CNT_W(CNT_W)) u_pos (
      .clk      (clk),
      .rst_n    (rst_n),
      .restart  (restart),
      .scl_in   (scl_in),
      .sample   (sample),
      .slot     (slot),
      .ack_slot (ack_slot)
   );

   arbfb_judge u_judge (
      .role_rx  (role_rx),
      .bit_val  (bit_val),
      .sda_in   (sda_in),
      .sample   (sample),
      .ack_slot (ack_slot),
      .lost     (lost_q),
      .sda_pull (sda_pull),
      .lose_now (lose_now)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        lost_q <= 1'b0;
      else if (restart)  lost_q <= 1'b0;
      else if (lose_now) lost_q <= 1'b1;
   end

   // clocking ends at the acknowledge sample of a byte in which arbitration was lost
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                   run_q <= 1'b1;
      else if (restart)                             run_q <= 1'b1;
      else if (sample && ack_slot && (lost_q || lose_now)) run_q <= 1'b0;
   end

   generate
      if (MSB_FIRST) begin : g_msb
         assign rx_nxt = {rx_q[DATA_BITS-2:0], sda_in};
      end else begin : g_lsb
         assign rx_nxt = {sda_in, rx_q[DATA_BITS-1:1]};
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                               rx_q <= '0;
      else if (!restart && sample && !ack_slot) rx_q <= rx_nxt;
   end

   always_comb begin
      if (lost_q)       mode = MODE_SRX;
      else if (role_rx) mode = MODE_MRX;
      else              mode = MODE_MTX;
   end

   assign sda_oe   = sda_pull;
   assign scl_oe   = scl_req & run_q;
   assign arb_lost = lost_q;
   assign mode_o   = mode;
   assign rx_data  = rx_q;
   logic unused_slot;
   assign unused_slot = ^slot;
endmodule

// File: rtl/i2c_arb_fallback_chk.sv
module i2c_arb_fallback_chk #(
   parameter int DATA_BITS = 8
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic                 restart,
   input logic                 role_rx,
   input logic                 bit_val,
   input logic                 scl_req,
   input logic                 scl_in,
   input logic                 sda_in,
   input logic                 sda_oe,
   input logic                 scl_oe,
   input logic                 arb_lost,
   input logic [1:0]           mode_o,
   input logic [DATA_BITS-1:0] rx_data
);
   assert_one_never_pulled_R2: assert property (@(posedge clk) disable iff (!rst_n)
      bit_val |-> !sda_oe);

   assert_loss_needs_low_line_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(arb_lost) |-> ($past(scl_in) && !$past(sda_in) && $past(bit_val)));

   assert_loss_gives_slave_mode_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(arb_lost) |-> (mode_o == 2'd2));

   assert_release_after_loss_R5: assert property (@(posedge clk) disable iff (!rst_n)
      arb_lost |-> !sda_oe);

   assert_scl_only_on_request_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !scl_req |-> !scl_oe);

   assert_flag_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (arb_lost && !restart) |=> arb_lost);

   assert_restart_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
      restart |=> !arb_lost);

   assert_rx_holds_while_high_R10: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(scl_in) && scl_in) |=> $stable(rx_data));

   logic unused_in;
   assign unused_in = role_rx;
endmodule

bind i2c_arb_fallback i2c_arb_fallback_chk #(.DATA_BITS(DATA_BITS)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .restart  (restart),
   .role_rx  (role_rx),
   .bit_val  (bit_val),
   .scl_req  (scl_req),
   .scl_in   (scl_in),
   .sda_in   (sda_in),
   .sda_oe   (sda_oe),
   .scl_oe   (scl_oe),
   .arb_lost (arb_lost),
   .mode_o   (mode_o),
   .rx_data  (rx_data)
);

// File: tb/i2c_arb_fallback_bench.sv
`timescale 1ns/1ps
module i2c_arb_fallback_bench;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic restart = 1'b0;
   logic role_rx = 1'b0;
   logic bit_val = 1'b1;
   logic scl_req = 1'b0;
   logic scl_in = 1'b1;
   logic sda_in = 1'b1;
   logic sda_oe, scl_oe, arb_lost;
   logic [1:0] mode_o;
   logic [7:0] rx_data;

   int n_checks = 0;
   int n_errors = 0;
   bit finished = 1'b0;

   always #4 clk = ~clk;

   i2c_arb_fallback u_i2c_arb_fallback (
      .clk(clk), .rst_n(rst_n), .restart(restart), .role_rx(role_rx),
      .bit_val(bit_val), .scl_req(scl_req), .scl_in(scl_in), .sda_in(sda_in),
      .sda_oe(sda_oe), .scl_oe(scl_oe), .arb_lost(arb_lost),
      .mode_o(mode_o), .rx_data(rx_data)
   );

   // behavioural reference: slot number, loss, clocking permission, byte seen
   int   m_slot;
   bit   m_prev_scl, m_lost, m_run;
   logic [7:0] m_rx;
   logic [7:0] m_q[$];

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_slot = 0; m_prev_scl = 1; m_lost = 0; m_run = 1; m_rx = 8'h00;
      end else begin
         bit rise, is_ack, mine, lose;
         rise = scl_in && !m_prev_scl;
         m_prev_scl = scl_in;
         if (restart) begin
            m_slot = 0; m_lost = 0; m_run = 1;
         end else if (rise) begin
            is_ack = (m_slot == 8);
            mine = role_rx ? is_ack : !is_ack;
            lose = mine && bit_val && !sda_in && !m_lost;
            if (!is_ack) begin
               m_q.push_back({7'b0, sda_in});
               m_rx = {m_rx[6:0], m_q.pop_front()[0]};
            end
            if (is_ack && (m_lost || lose)) m_run = 0;
            if (lose) m_lost = 1;
            m_slot = is_ack ? 0 : m_slot + 1;
         end
      end
   end

   task automatic check(input string tag, input logic [7:0] got, input logic [7:0] exp);
      n_checks++;
      if (got !== exp) begin
         n_errors++;
         $display("FAIL %s: got %h expected %h at %0t", tag, got, exp, $time);
      end
   endtask

   always @(negedge clk) begin
      #3;
      if (rst_n && !finished) begin
         bit mine;
         mine = role_rx ? (m_slot == 8) : (m_slot != 8);
         check("R2 sda_oe", {7'b0, sda_oe}, {7'b0, mine && !bit_val && !m_lost});
         check("R6 scl_oe", {7'b0, scl_oe}, {7'b0, scl_req && m_run});
         check("R3 arb_lost", {7'b0, arb_lost}, {7'b0, m_lost});
         check("R3 mode_o", {6'b0, mode_o}, m_lost ? 8'd2 : (role_rx ? 8'd1 : 8'd0));
         check("R8 rx_data", rx_data, m_rx);
      end
   end

   task automatic bus_bit(input logic drv, input logic line);
      @(negedge clk); scl_in = 0; scl_req = 1; bit_val = drv;
      repeat (2) @(negedge clk);
      sda_in = line;
      repeat (2) @(negedge clk);
      scl_in = 1; scl_req = 0;
      repeat (4) @(negedge clk);
   endtask

   task automatic do_byte(input logic [7:0] drv, input logic [7:0] bus,
                          input logic ack_drv, input logic ack_bus);
      for (int i = 7; i >= 0; i--) bus_bit(drv[i], bus[i]);
      bus_bit(ack_drv, ack_bus);
   endtask

   task automatic do_restart();
      @(negedge clk); restart = 1;
      @(negedge clk); restart = 0;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      #3;
      check("R1 reset sda_oe", {7'b0, sda_oe}, 8'd0);
      check("R1 reset arb_lost", {7'b0, arb_lost}, 8'd0);
      check("R1 reset rx_data", rx_data, 8'h00);
      check("R1 reset mode_o", {6'b0, mode_o}, 8'd0);
      @(negedge clk); rst_n = 1;

      // clean transmit, low acknowledge while released (R4, R10)
      do_byte(8'hA5, 8'hA5, 1'b1, 1'b0);
      #3;
      check("R4 no flag on tx ack", {7'b0, arb_lost}, 8'd0);
      check("R8 clean byte", rx_data, 8'hA5);

      // transmit loss on third bit; winner sends C3
      do_restart();
      do_byte(8'hF0, 8'hC3, 1'b1, 1'b0);
      #3;
      check("R3 tx loss flagged", {7'b0, arb_lost}, 8'd1);
      check("R3 slave mode", {6'b0, mode_o}, 8'd2);
      check("R8 winner byte kept", rx_data, 8'hC3);
      @(negedge clk); scl_in = 0; scl_req = 1; bit_val = 0;
      #3;
      check("R6 clock halted after byte", {7'b0, scl_oe}, 8'd0);
      check("R5 sda released", {7'b0, sda_oe}, 8'd0);
      repeat (20) @(negedge clk);
      #3;
      check("R9 flag sticky", {7'b0, arb_lost}, 8'd1);
      @(negedge clk); scl_in = 1; scl_req = 0;

      // receive with overruled not-acknowledge
      do_restart();
      #3;
      check("R9 restart clears", {7'b0, arb_lost}, 8'd0);
      @(negedge clk); role_rx = 1;
      do_byte(8'h00, 8'h5A, 1'b1, 1'b0);
      #3;
      check("R7 rx nack loss", {7'b0, arb_lost}, 8'd1);
      check("R8 rx byte", rx_data, 8'h5A);
      @(negedge clk); scl_in = 0; scl_req = 1;
      #3;
      check("R7 no clock after ack loss", {7'b0, scl_oe}, 8'd0);
      @(negedge clk); scl_in = 1; scl_req = 0;

      // receive: low data while released, then nack seen high, then ack driven
      do_restart();
      do_byte(8'hFF, 8'h00, 1'b1, 1'b1);
      #3;
      check("R4 rx data slots unchecked", {7'b0, arb_lost}, 8'd0);
      do_byte(8'h00, 8'h81, 1'b0, 1'b0);
      #3;
      check("R7 ack byte no loss", {7'b0, arb_lost}, 8'd0);
      check("R8 second rx byte", rx_data, 8'h81);

      // transmit all ones with acknowledge
      @(negedge clk); role_rx = 0;
      do_restart();
      do_byte(8'hFF, 8'hFF, 1'b1, 1'b0);
      #3;
      check("R4 tx ack released", {7'b0, arb_lost}, 8'd0);
      check("R10 one sample per bit", rx_data, 8'hFF);

      finished = 1;
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
   end

   initial begin
      repeat (50000) @(posedge clk);
      if (!finished) begin
         finished = 1;
         n_checks++; n_errors++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
         $finish;
      end
   end
endmodule